// File: doc/BRIEF.md
# Configuration Stream Packet Decoder with CRC Verification

This block sits on a 16-bit word stream read from a configuration image. It ignores everything until it has seen the two-word alignment pattern. Once it finds that pattern it locks onto the stream and reads each following word as a packet header or as packet payload. Every payload word of an ordinary register write is reported on a strobe with its register address and value. The word is also folded into a running 32-bit checksum.

A write to the checksum register carries the expected checksum. The block compares it with the checksum it has accumulated and pulses an error strobe when the two differ. A dedicated terminating command ends a clean load with a done strobe. No done strobe follows once any checksum mismatch has been recorded. A loader can use this to detect a truncated or corrupted image and switch to a fallback image.

Top module: `cfgdec_top`

## Requirements
- R1: Until the alignment pattern has been seen, no word is decoded: `reg_wr`, `crc_err` and `done` stay low, and `sync_found` stays low, whatever the words are.
- R2: The alignment pattern is the valid word 0xAA99 followed by the valid word 0x5566 (cycles with `in_valid` low in between are skipped). `sync_found` rises in the cycle after the 0x5566 word is taken. It then stays high until reset.
- R3: A header word is split as bits 15:13 class, 12:11 operation, 10:5 register address and 4:0 word count. Class 3'b001 with operation 2'b10 and a count N>0 is a write. The next N valid words are its payload. Each payload word produces a one-cycle `reg_wr` in the following cycle, with `reg_addr` set to the header address and `reg_data` set to the word.
- R4: Any other header is skipped and produces no strobe: operation 2'b00 (no-op), any other class or operation, or a count of zero. The next valid word is again read as a header.
- R5: The running checksum is the CRC-32C polynomial 0x1EDC6F41, computed MSB first, non-reflected, with an initial value of zero. It takes in 22 bits per payload word, {address[5:0], data[15:0]}, for every write to a nonzero address. It is cleared when alignment is found and after every checksum comparison.
- R6: A write to address 6'h00 (header 0x3002) carries the expected checksum in two payload words, the upper half first. After the second word, `crc_err` pulses in the following cycle if {upper, lower} differs from the running checksum. Otherwise `crc_err` stays low.
- R7: A payload word 0x0005 to address 6'h05 is the terminating command. `done` pulses in the following cycle only if no checksum mismatch has occurred since reset.
- R8: After lock, a further 0xAA99/0x5566 pair is ordinary stream content. Used as write payload, it produces normal `reg_wr` strobes.
- R9: In reset and right after it, all outputs are low.
- R10: A cycle with `in_valid` low changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word present this cycle |
| in_word | input | 16 | Stream word |
| sync_found | output | 1 | Alignment pattern found, stream locked |
| reg_wr | output | 1 | One-cycle strobe per write payload word |
| reg_addr | output | 6 | Register address of the strobed word |
| reg_data | output | 16 | Payload value of the strobed word |
| crc_err | output | 1 | One-cycle strobe on checksum mismatch |
| done | output | 1 | One-cycle strobe on a clean terminating command |

## Verification
The properties assume that `in_valid` and `in_word` are stable across each clock edge. They also assume that `rst_n` is held for at least one edge before the stream starts. They rely on the strobes being registered, so that every strobe traces back to the word taken one edge earlier. The stimulus drives all inputs on the falling edge only, and starts a stream only after a full reset. Its random packets use arbitrary headers and counts, which exercises every skip and write path without ever breaking the one-word-per-edge rule.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int CNT_W   = 5;
  localparam int CLS_W   = 3;
  localparam int OP_W    = 2;
  localparam int CRC_W   = 32;
  localparam int FEED_W  = ADDR_W + WORD_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'h1EDC6F41;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
  } hdr_t;

  typedef enum logic {PS_HEADER, PS_PAYLOAD} pstate_t;

  // One MSB-first step per bit: shift, then fold in the polynomial when
  // the outgoing bit and the incoming bit differ.
  function automatic logic [CRC_W-1:0] crc_feed(
    input logic [CRC_W-1:0]  crc_in,
    input logic [FEED_W-1:0] bits
  );
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = FEED_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ bits[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    end
    return c;
  endfunction
endpackage

// File: rtl/cfgdec_sync_hunt.sv
module cfgdec_sync_hunt
  import cfgdec_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_HI = 16'hAA99,
  parameter logic [WORD_W-1:0] SYNC_LO = 16'h5566
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              locked,
  output logic              sync_hit
);
  logic seen_hi;

  assign sync_hit = in_valid && !locked && seen_hi && (in_word == SYNC_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      seen_hi <= 1'b0;
    end else begin
      if (sync_hit) locked <= 1'b1;
      if (in_valid && !locked) seen_hi <= (in_word == SYNC_HI);
    end
  end
endmodule

// File: rtl/cfgdec_pkt_parse.sv
module cfgdec_pkt_parse
  import cfgdec_pkg::*;
#(
  parameter logic [CLS_W-1:0]  CLS_T1    = 3'b001,
  parameter logic [OP_W-1:0]   OP_WRITE  = 2'b10,
  parameter logic [ADDR_W-1:0] CRC_ADDR  = 6'h00,
  parameter logic [ADDR_W-1:0] TERM_ADDR = 6'h05,
  parameter logic [WORD_W-1:0] TERM_VAL  = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_ok,
  input  logic [WORD_W-1:0] in_word,
  output logic              ev_wr,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              ev_acc,
  output logic              ev_crc_hi,
  output logic              ev_crc_chk,
  output logic              ev_term
);
  pstate_t           st;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] cur_addr;
  logic              pair;
  hdr_t              hdr;
  logic              hdr_write;
  logic              to_crc;

  assign hdr       = hdr_t'(in_word);
  assign hdr_write = word_ok && (st == PS_HEADER) && (hdr.cls == CLS_T1)
                     && (hdr.op == OP_WRITE) && (hdr.cnt != '0);

  always_comb begin
    ev_wr      = word_ok && (st == PS_PAYLOAD);
    ev_addr    = cur_addr;
    to_crc     = (cur_addr == CRC_ADDR);
    ev_acc     = ev_wr && !to_crc;
    ev_crc_hi  = ev_wr && to_crc && !pair;
    ev_crc_chk = ev_wr && to_crc && pair;
    ev_term    = ev_wr && (cur_addr == TERM_ADDR) && (in_word == TERM_VAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_HEADER;
      remain   <= '0;
      cur_addr <= '0;
      pair     <= 1'b0;
    end else if (hdr_write) begin
      st       <= PS_PAYLOAD;
      remain   <= hdr.cnt;
      cur_addr <= hdr.addr;
      pair     <= 1'b0;
    end else if (ev_wr) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) st <= PS_HEADER;
      if (to_crc) pair <= !pair;
    end
  end
endmodule

// File: rtl/cfgdec_crc_acc.sv
module cfgdec_crc_acc
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              acc,
  input  logic              hi_ld,
  input  logic              chk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              mismatch
);
  logic [CRC_W-1:0]  crc_q;
  logic [WORD_W-1:0] hi_q;

  assign mismatch = chk && ({hi_q, data} != crc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '0;
      hi_q  <= '0;
    end else begin
      if (clear || chk) crc_q <= '0;
      else if (acc)     crc_q <= crc_feed(crc_q, {addr, data});
      if (hi_ld) hi_q <= data;
    end
  end
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
  import cfgdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        sync_found,
  output logic        reg_wr,
  output logic [5:0]  reg_addr,
  output logic [15:0] reg_data,
  output logic        crc_err,
  output logic        done
);
  logic              locked;
  logic              sync_hit;
  logic              ev_wr, ev_acc, ev_crc_hi, ev_crc_chk, ev_term;
  logic [ADDR_W-1:0] ev_addr;
  logic              crc_mismatch;
  logic              err_seen;

  cfgdec_sync_hunt u_hunt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .locked(locked), .sync_hit(sync_hit)
  );

  cfgdec_pkt_parse u_parse (
    .clk(clk), .rst_n(rst_n), .word_ok(in_valid && locked), .in_word(in_word),
    .ev_wr(ev_wr), .ev_addr(ev_addr), .ev_acc(ev_acc),
    .ev_crc_hi(ev_crc_hi), .ev_crc_chk(ev_crc_chk), .ev_term(ev_term)
  );

  cfgdec_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(sync_hit), .acc(ev_acc),
    .hi_ld(ev_crc_hi), .chk(ev_crc_chk), .addr(ev_addr), .data(in_word),
    .mismatch(crc_mismatch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_found <= 1'b0;
      reg_wr     <= 1'b0;
      reg_addr   <= '0;
      reg_data   <= '0;
      crc_err    <= 1'b0;
      done       <= 1'b0;
      err_seen   <= 1'b0;
    end else begin
      sync_found <= locked || sync_hit;
      reg_wr     <= ev_wr;
      if (ev_wr) begin
        reg_addr <= ev_addr;
        reg_data <= in_word;
      end
      crc_err  <= crc_mismatch;
      done     <= ev_term && !err_seen;
      if (crc_mismatch) err_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_word,
  input logic        sync_found,
  input logic        reg_wr,
  input logic [5:0]  reg_addr,
  input logic [15:0] reg_data,
  input logic        crc_err,
  input logic        done,
  input logic        err_seen
);
  p_wr_needs_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> sync_found);

  p_lock_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> sync_found);

  p_lock_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_found) |-> ($past(in_valid) && $past(in_word) == 16'h5566));

  p_err_on_crc_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (reg_wr && reg_addr == 6'h00));

  p_done_is_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reg_wr && reg_addr == 6'h05 && reg_data == 16'h0005));

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err_seen);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!reg_wr && !crc_err && !done));
endmodule

bind cfgdec_top cfgdec_checker chk_i (.*);

// File: tb/cfgdec_top_tb_top.sv
`timescale 1ns/1ps
module cfgdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        sync_found, reg_wr, crc_err, done;
  logic [5:0]  reg_addr;
  logic [15:0] reg_data;

  cfgdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .sync_found(sync_found), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .crc_err(crc_err), .done(done)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    n_done = 0;
  int    n_err = 0;
  string req = "R9";

  // bench model state
  bit          m_lock, m_prev_hi, m_pay, m_pair, m_bad;
  int          m_rem;
  logic [5:0]  m_addr;
  logic [15:0] m_hi;
  logic [31:0] m_crc;

  function automatic logic [31:0] crc_model(logic [31:0] c, logic [5:0] a, logic [15:0] d);
    logic [21:0] v;
    v = {a, d};
    for (int i = 0; i < 22; i++) begin
      bit top;
      top = c[31];
      c = c << 1;
      if (top != v[21-i]) c = c ^ 32'h1EDC6F41;
    end
    return c;
  endfunction

  function automatic logic [15:0] mk_hdr(int cls, int op, int a, int n);
    return {cls[2:0], op[1:0], a[5:0], n[4:0]};
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 0; m_prev_hi = 0; m_pay = 0; m_pair = 0; m_bad = 0;
    m_rem = 0; m_addr = '0; m_hi = '0; m_crc = '0;
  endtask

  task automatic push(bit v, logic [15:0] d);
    bit e_wr, e_err, e_done;
    logic [5:0] e_addr;
    e_wr = 0; e_err = 0; e_done = 0; e_addr = '0;
    if (v) begin
      if (!m_lock) begin
        if (m_prev_hi && d == 16'h5566) begin m_lock = 1; m_crc = '0; end
        m_prev_hi = (d == 16'hAA99);
      end else if (!m_pay) begin
        if (d[15:13] == 3'b001 && d[12:11] == 2'b10 && d[4:0] != 0) begin
          m_pay = 1; m_rem = d[4:0]; m_addr = d[10:5]; m_pair = 0;
        end
      end else begin
        e_wr = 1; e_addr = m_addr;
        if (m_addr == 6'h00) begin
          if (!m_pair) begin m_hi = d; m_pair = 1; end
          else begin
            if ({m_hi, d} != m_crc) e_err = 1;
            m_crc = '0; m_pair = 0;
          end
        end else m_crc = crc_model(m_crc, m_addr, d);
        if (m_addr == 6'h05 && d == 16'h0005 && !m_bad) e_done = 1;
        if (e_err) m_bad = 1;
        m_rem--;
        if (m_rem == 0) m_pay = 0;
      end
    end
    in_valid = v; in_word = d;
    @(negedge clk);
    chk("sync_found", sync_found, m_lock);
    chk("reg_wr", reg_wr, e_wr);
    if (e_wr) begin
      chk("reg_addr", reg_addr, e_addr);
      chk("reg_data", reg_data, d);
    end
    chk("crc_err", crc_err, e_err);
    chk("done", done, e_done);
    if (e_done) n_done++;
    if (e_err) n_err++;
  endtask

  task automatic do_reset();
    in_valid = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    req = "R9";
    chk("reset outputs", {sync_found, reg_wr, crc_err, done}, 4'b0);
    rst_n = 1;
    model_reset();
  endtask

  task automatic send_sync();
    req = "R2";
    push(1, 16'hAA99);
    push(1, 16'h5566);
    chk("R2 locked after pattern", sync_found, 1'b1);
  endtask

  task automatic send_crc(bit corrupt);
    logic [31:0] c;
    c = m_crc ^ (corrupt ? 32'h0000_0100 : 32'h0);
    push(1, 16'h3002);
    push(1, c[31:16]);
    push(1, c[15:0]);
  endtask

  task automatic rand_round(int npk, bit allow_bad);
    for (int p = 0; p < npk; p++) begin
      int kind;
      kind = $urandom_range(0, 11);
      if ($urandom_range(0, 3) == 0) push(0, 16'($urandom));
      if (kind <= 5) begin
        int n;
        int a;
        n = $urandom_range(1, 4);
        a = $urandom_range(1, 63);
        push(1, mk_hdr(1, 2, a, n));
        for (int k = 0; k < n; k++) begin
          if ($urandom_range(0, 4) == 0) push(0, 16'hAA99);
          push(1, 16'($urandom));
        end
      end else if (kind == 6) push(1, mk_hdr(1, 0, $urandom_range(0, 63), $urandom_range(0, 31)));
      else if (kind == 7) push(1, mk_hdr($urandom_range(2, 7), $urandom_range(0, 3), 0, 2));
      else if (kind == 8 || (kind == 9 && !allow_bad)) send_crc(0);
      else if (kind == 9) send_crc(1);
      else begin push(1, mk_hdr(1, 2, 5, 1)); push(1, 16'h0005); end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL all watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0;
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R1: no decoding before lock
    req = "R1";
    push(1, 16'h3002); push(1, 16'h1234);
    push(1, mk_hdr(1, 2, 5, 1)); push(1, 16'h0005);
    push(1, 16'hAA99); push(1, 16'h1111); push(1, 16'h5566);
    chk("R1 still unlocked", sync_found, 1'b0);

    // R10 + R2: idle cycle between the two pattern words
    req = "R10";
    push(1, 16'hAA99); push(0, 16'h5566); push(0, 16'h0000);
    chk("R10 idle no lock", sync_found, 1'b0);
    req = "R2";
    push(1, 16'h5566);
    chk("R2 lock", sync_found, 1'b1);

    // R3 write with count 3
    req = "R3";
    push(1, mk_hdr(1, 2, 3, 3));
    push(1, 16'hA001); push(0, 16'h0); push(1, 16'hA002); push(1, 16'hA003);

    // R4 skipped headers
    req = "R4";
    push(1, mk_hdr(1, 0, 7, 3)); push(1, mk_hdr(2, 2, 7, 1));
    push(1, mk_hdr(1, 2, 9, 0)); push(1, mk_hdr(1, 1, 4, 2));
    chk("R4 no strobe after skip", reg_wr, 1'b0);

    // R8 pattern as payload after lock
    req = "R8";
    push(1, mk_hdr(1, 2, 7, 2)); push(1, 16'hAA99); push(1, 16'h5566);
    chk("R8 second pattern strobed", reg_addr, 6'd7);

    // R5/R6 good then bad checksum
    req = "R5";
    d0 = n_err;
    send_crc(0);
    chk("R5 matching checksum no error", n_err - d0, 0);
    push(1, mk_hdr(1, 2, 12, 1)); push(1, 16'h0BAD);
    req = "R6";
    send_crc(1);
    chk("R6 mismatch flagged", n_err - d0, 1);

    // R7 terminate after error: no done
    req = "R7";
    d0 = n_done;
    push(1, mk_hdr(1, 2, 5, 1)); push(1, 16'h0005);
    chk("R7 no done after error", n_done - d0, 0);

    // R7 clean run
    do_reset();
    send_sync();
    req = "R7";
    push(1, mk_hdr(1, 2, 5, 2)); push(1, 16'h0004); push(1, 16'h0005);
    chk("R7 done on clean terminate", n_done - d0, 1);

    // random rounds
    req = "R3";
    rand_round(200, 1'b1);
    do_reset();
    send_sync();
    req = "R6";
    rand_round(200, 1'b0);
    chk("R6 no error in clean round", m_bad, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule